// File: doc/BRIEF.md
# Start-up Reset Sequencer

This block merges the chip's reset sources into one internal reset: the power-on flag, a brown-out comparator output that can be enabled, and an active-low multifunction pin. After the last source goes away it keeps reset asserted for a start-up delay. The delay is measured in 1 µs timebase ticks. Two start-up configuration bits and the oscillator type (RC/external clock or crystal) select its length.

The multifunction pin goes through a synchronizer and a low-level qualifier. It can act as a reset input or as a plain input. During the power-up phase it always acts as a reset input. After that phase, a sampled configuration bit chooses its role. The same pin also asks for in-system-programming entry. The request follows the pin while the pin is in reset mode. In input mode the request can only occur during the power-up phase.

Top module: `rsq_top`

## Requirements
- R1: When `bod_en_i` and `bod_low_i` are both 1, `rst_o` is 1 in the same cycle, with no clocked delay.
- R2: When `bod_en_i` is 0, `bod_low_i` has no effect on `rst_o`.
- R3: After all causes clear, `rst_o` stays 1 for N more ticks and is then 0. N depends on `{sut_i[1], sut_i[0]}`. With `xtal_sel_i`=0 (RC/external clock): 00→16, 01→512, 10→1024, 11→4096. With `xtal_sel_i`=1 (crystal): 00→1024, 01→2048, 10→4096, 11→16384. After `por_i` falls, with ticks every cycle, `rst_o` is 0 after exactly N rising edges.
- R4: Any reset cause that appears during the countdown reloads the full delay. Release then comes N ticks after that cause clears.
- R5: In reset mode, the pin raises `rst_o` only after two consecutive synchronized low samples. A pin low for 2 cycles gives `rst_o`=1 four edges after the low begins. A pin low for a single cycle is ignored.
- R6: During the power-up phase the pin acts as reset, whatever `pin_rst_en_i` is. A pin held low extends reset until the pin goes high.
- R7: After the power-up phase, `pin_is_reset_o` equals the sampled enable bit. In input mode (0) a low pin causes no reset.
- R8: `isp_req_o` is 1 only while the qualified pin level is low and the pin is in reset mode. In input mode the request can therefore come only from a low pin during the power-up phase.
- R9: `pin_rst_en_i` is sampled only while `rst_o` is 1. While reset is 0, changes to it have no effect.
- R10: While `por_i` is 1, `rst_o`=1, `pin_is_reset_o`=1, and `isp_req_o`=0 when the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset flag, active high; forces all state to defaults |
| tick_us_i | input | 1 | 1 µs timebase strobe |
| bod_low_i | input | 1 | Brown-out comparator: supply below threshold |
| bod_en_i | input | 1 | Brown-out detection enable |
| pin_rst_en_i | input | 1 | 1 = pin acts as reset after power-up, 0 = plain input |
| sut_i | input | 2 | Start-up delay select |
| xtal_sel_i | input | 1 | 1 = crystal, 0 = RC/external clock |
| pin_raw_i | input | 1 | Raw multifunction pin level (active-low reset) |
| rst_o | output | 1 | Internal reset, active high |
| pin_is_reset_o | output | 1 | 1 = pin currently acts as reset input |
| isp_req_o | output | 1 | In-system-programming entry request |

## Verification
The bench measures every release delay from the eight-entry table edge by edge. An off-by-one count or a swapped RC/crystal column would show up as a wrong count. It sends 1-cycle and 2-cycle pin pulses. A design without the qualifier would reset on the 1-cycle glitch, and an overly long qualifier would miss the 2-cycle pulse. A brown-out pulse in the middle of a countdown must restart the full delay; a design that resumed the old count would release early. It also holds the pin low through power-up with the enable cleared, changes the enable while out of reset, and toggles the brown-out flag with detection disabled. These cases catch an enable bit that is not forced during power-up, configuration that leaks through outside reset, and detection that ignores its enable.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
   // oscillator kind selects which column of the delay table applies
   typedef enum logic {
      CLK_RC   = 1'b0,
      CLK_XTAL = 1'b1
   } clk_kind_e;

   localparam int unsigned SUT_CODES = 4;
endpackage

// File: rtl/rsq_pin_filter.sv
module rsq_pin_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LOW_CYCLES  = 2
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic pin_raw_i,
   output logic low_qual_o
);
   localparam int unsigned LCW = $clog2(LOW_CYCLES + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [LCW-1:0]         low_cnt_q;
   logic                   pin_sync;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rsq_pin_filter: SYNC_STAGES must be at least 2");
      end
      if (LOW_CYCLES < 1) begin : g_bad_low
         $error("rsq_pin_filter: LOW_CYCLES must be at least 1");
      end
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (por_i) sync_q[0] <= 1'b1;
               else       sync_q[0] <= pin_raw_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (por_i) sync_q[s] <= 1'b1;
               else       sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   assign pin_sync = sync_q[SYNC_STAGES-1];

   // saturating run-length count of synchronized low samples
   always_ff @(posedge clk_i) begin
      if (por_i || pin_sync) begin
         low_cnt_q <= '0;
      end else if (low_cnt_q != LCW'(LOW_CYCLES)) begin
         low_cnt_q <= low_cnt_q + 1'b1;
      end
   end

   assign low_qual_o = (low_cnt_q == LCW'(LOW_CYCLES));
endmodule

// File: rtl/rsq_timer.sv
module rsq_timer #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk_i,
   input  logic             por_i,
   input  logic             tick_i,
   input  logic             cause_i,
   input  logic [CNT_W-1:0] load_i,
   output logic             busy_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (por_i || cause_i) begin
         cnt_q <= load_i;
      end else if (tick_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/rsq_top.sv
module rsq_top
   import rsq_pkg::*;
#(
   parameter int unsigned CNT_W       = 15,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LOW_CYCLES  = 2,
   parameter int unsigned RC_DLY [SUT_CODES] = '{16, 512, 1024, 4096},
   parameter int unsigned XT_DLY [SUT_CODES] = '{1024, 2048, 4096, 16384}
) (
   input  logic       clk_i,
   input  logic       por_i,
   input  logic       tick_us_i,
   input  logic       bod_low_i,
   input  logic       bod_en_i,
   input  logic       pin_rst_en_i,
   input  logic [1:0] sut_i,
   input  logic       xtal_sel_i,
   input  logic       pin_raw_i,
   output logic       rst_o,
   output logic       pin_is_reset_o,
   output logic       isp_req_o
);
   localparam longint unsigned CNT_LIMIT = 64'd1 << CNT_W;

   generate
      for (genvar i = 0; i < SUT_CODES; i++) begin : g_chk_dly
         if (RC_DLY[i] == 0 || RC_DLY[i] >= CNT_LIMIT) begin : g_bad_rc
            $error("rsq_top: RC delay entry out of counter range");
         end
         if (XT_DLY[i] == 0 || XT_DLY[i] >= CNT_LIMIT) begin : g_bad_xt
            $error("rsq_top: crystal delay entry out of counter range");
         end
      end
   endgenerate

   logic             powerup_q;
   logic             pin_en_q;
   logic             pin_low_q;
   logic             pin_mode;
   logic             bod_cause;
   logic             pin_cause;
   logic             cause_any;
   logic             busy;
   logic [CNT_W-1:0] load_val;
   clk_kind_e        clk_kind;

   assign clk_kind = clk_kind_e'(xtal_sel_i);

   always_comb begin
      if (clk_kind == CLK_XTAL) load_val = CNT_W'(XT_DLY[sut_i]);
      else                      load_val = CNT_W'(RC_DLY[sut_i]);
   end

   rsq_pin_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .LOW_CYCLES  (LOW_CYCLES)
   ) i_pin_filter (
      .clk_i      (clk_i),
      .por_i      (por_i),
      .pin_raw_i  (pin_raw_i),
      .low_qual_o (pin_low_q)
   );

   assign pin_mode  = powerup_q | pin_en_q;
   assign pin_cause = pin_mode & pin_low_q;
   assign bod_cause = bod_en_i & bod_low_i;
   assign cause_any = bod_cause | pin_cause;

   rsq_timer #(
      .CNT_W (CNT_W)
   ) i_timer (
      .clk_i   (clk_i),
      .por_i   (por_i),
      .tick_i  (tick_us_i),
      .cause_i (cause_any),
      .load_i  (load_val),
      .busy_o  (busy)
   );

   // power-up phase ends with the first full release; enable bit is sampled under reset only
   always_ff @(posedge clk_i) begin
      if (por_i) begin
         powerup_q <= 1'b1;
         pin_en_q  <= pin_rst_en_i;
      end else begin
         if (rst_o)                  pin_en_q  <= pin_rst_en_i;
         if (!cause_any && !busy)    powerup_q <= 1'b0;
      end
   end

   assign rst_o          = por_i | cause_any | busy;
   assign pin_is_reset_o = pin_mode;
   assign isp_req_o      = pin_low_q & pin_mode;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker (
   input logic clk_i,
   input logic por_i,
   input logic tick_us_i,
   input logic bod_en_i,
   input logic bod_low_i,
   input logic pin_raw_i,
   input logic rst_o,
   input logic pin_is_reset_o,
   input logic isp_req_o
);
   assert_bod_immediate_R1: assert property (@(posedge clk_i) disable iff (por_i)
      (bod_en_i && bod_low_i) |-> rst_o);

   assert_release_on_tick_R3: assert property (@(posedge clk_i) disable iff (por_i)
      $fell(rst_o) |-> $past(tick_us_i));

   assert_pin_qualified_R5: assert property (@(posedge clk_i) disable iff (por_i)
      ($rose(rst_o) && !(bod_en_i && bod_low_i)) |->
         (!$past(pin_raw_i, 3) && !$past(pin_raw_i, 4)));

   assert_mode_frozen_R9: assert property (@(posedge clk_i) disable iff (por_i)
      (!rst_o && !$past(rst_o) && !$past(rst_o, 2)) |-> $stable(pin_is_reset_o));

   assert_isp_mode_R8: assert property (@(posedge clk_i) disable iff (por_i)
      isp_req_o |-> pin_is_reset_o);

   assert_isp_pin_low_R8: assert property (@(posedge clk_i) disable iff (por_i)
      isp_req_o |-> (!$past(pin_raw_i, 3) && !$past(pin_raw_i, 4)));
endmodule

bind rsq_top rsq_checker i_rsq_checker (
   .clk_i          (clk_i),
   .por_i          (por_i),
   .tick_us_i      (tick_us_i),
   .bod_en_i       (bod_en_i),
   .bod_low_i      (bod_low_i),
   .pin_raw_i      (pin_raw_i),
   .rst_o          (rst_o),
   .pin_is_reset_o (pin_is_reset_o),
   .isp_req_o      (isp_req_o)
);

// File: tb/test_rsq_top.sv
module test_rsq_top;
   logic       clk = 1'b0;
   logic       por = 1'b1;
   logic       tick = 1'b1;
   logic       bod_low = 1'b0;
   logic       bod_en = 1'b0;
   logic       pin_en = 1'b1;
   logic [1:0] sut = 2'b00;
   logic       xtal = 1'b0;
   logic       pin = 1'b1;
   logic       rst, pin_rst, isp;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rsq_top i_rsq_top (
      .clk_i(clk), .por_i(por), .tick_us_i(tick), .bod_low_i(bod_low),
      .bod_en_i(bod_en), .pin_rst_en_i(pin_en), .sut_i(sut), .xtal_sel_i(xtal),
      .pin_raw_i(pin), .rst_o(rst), .pin_is_reset_o(pin_rst), .isp_req_o(isp)
   );

   // {sut, xtal, expected ticks}
   localparam logic [17:0] VEC [8] = '{
      {2'b00, 1'b0, 15'd16},   {2'b01, 1'b0, 15'd512},
      {2'b10, 1'b0, 15'd1024}, {2'b11, 1'b0, 15'd4096},
      {2'b00, 1'b1, 15'd1024}, {2'b01, 1'b1, 15'd2048},
      {2'b10, 1'b1, 15'd4096}, {2'b11, 1'b1, 15'd16384}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic power_up(input logic [1:0] s, input logic x, input logic en, input logic p);
      @(negedge clk);
      por = 1'b1; sut = s; xtal = x; pin_en = en; pin = p;
      cycles(3);
      por = 1'b0;
   endtask

   // rising edges from now until rst is observed low
   task automatic count_release(output int n);
      n = 0;
      do begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end while (rst && n < 40000);
   endtask

   initial begin
      int n;
      // R10: defaults under power-on
      cycles(2);
      check(rst == 1'b1, "R10 rst during por", rst, 1);
      check(pin_rst == 1'b1, "R10 pin mode during por", pin_rst, 1);
      check(isp == 1'b0, "R10 isp during por", isp, 0);

      // R3: delay table walk
      for (int v = 0; v < 8; v++) begin
         power_up(VEC[v][17:16], VEC[v][15], 1'b1, 1'b1);
         count_release(n);
         check(n == int'(VEC[v][14:0]), $sformatf("R3 delay sut=%0d xtal=%0d",
               VEC[v][17:16], VEC[v][15]), n, int'(VEC[v][14:0]));
      end

      // R1/R4: brown-out mid-countdown restarts full delay
      power_up(2'b00, 1'b0, 1'b1, 1'b1);
      cycles(5);
      bod_en = 1'b1; bod_low = 1'b1;
      #1 check(rst == 1'b1, "R1 immediate bod reset", rst, 1);
      @(negedge clk);
      bod_low = 1'b0;
      count_release(n);
      check(n == 16, "R4 restart after bod", n, 16);

      // R1 again out of reset, same-cycle response
      cycles(4);
      bod_low = 1'b1;
      #1 check(rst == 1'b1, "R1 bod while idle", rst, 1);
      @(negedge clk);
      bod_low = 1'b0;
      count_release(n);
      check(n == 16, "R4 release after bod", n, 16);

      // R2: disabled brown-out ignored
      bod_en = 1'b0; bod_low = 1'b1;
      cycles(6);
      check(rst == 1'b0, "R2 bod disabled", rst, 0);
      bod_low = 1'b0;

      // R5: single-cycle glitch ignored
      begin
         int hi = 0;
         pin = 1'b0; @(negedge clk); pin = 1'b1;
         for (int i = 0; i < 8; i++) begin @(negedge clk); if (rst) hi++; end
         check(hi == 0, "R5 one-cycle pulse ignored", hi, 0);
      end

      // R5: two-cycle pulse triggers four edges after start
      pin = 1'b0; cycles(2); pin = 1'b1; cycles(2);
      check(rst == 1'b1, "R5 two-cycle pulse resets", rst, 1);
      count_release(n);
      check(!rst, "R5 released after pulse", rst, 0);

      // R8: held low in reset mode requests programming
      cycles(3);
      pin = 1'b0; cycles(6);
      check(isp == 1'b1, "R8 isp in reset mode", isp, 1);
      check(rst == 1'b1, "R5 held low resets", rst, 1);
      pin = 1'b1;
      count_release(n);
      cycles(3);

      // R9: enable bit change while out of reset ignored
      pin_en = 1'b0; cycles(5);
      check(pin_rst == 1'b1, "R9 enable frozen outside reset", pin_rst, 1);
      pin = 1'b0; cycles(5);
      check(rst == 1'b1, "R9 pin still resets", rst, 1);
      pin = 1'b1;
      count_release(n);
      cycles(3);
      check(pin_rst == 1'b0, "R9 enable sampled during reset", pin_rst, 0);

      // R7: input mode, low pin no reset and no isp
      pin = 1'b0; cycles(10);
      check(rst == 1'b0, "R7 input mode no reset", rst, 0);
      check(isp == 1'b0, "R8 no isp in input mode", isp, 0);
      pin = 1'b1; cycles(3);

      // R6: power-up with enable 0 and pin held low
      power_up(2'b00, 1'b0, 1'b0, 1'b0);
      cycles(40);
      check(rst == 1'b1, "R6 held pin extends reset", rst, 1);
      check(pin_rst == 1'b1, "R6 pin is reset in power-up", pin_rst, 1);
      check(isp == 1'b1, "R8 isp during power-up", isp, 1);
      pin = 1'b1;
      count_release(n);
      check(!rst, "R6 release after pin high", rst, 0);
      cycles(3);
      check(pin_rst == 1'b0, "R7 input mode after power-up", pin_rst, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < 190000; c++) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule